// File: doc/BRIEF.md
# Byte-Wide EEPROM Access and Burst Loader

This controller sits between a host register port and an external byte-wide EEPROM. The host can start single-byte reads and writes. It can also start a burst that streams records out of the EEPROM and writes them into on-chip memory. The EEPROM is reached through a request/acknowledge byte handshake. One byte moves per acknowledge. The on-chip memory is reached through a write-only port with a 24-bit address.

A burst reads records in a loop. Each record is a 2-byte address word followed by a 4-byte data word, and both are taken least significant byte first. The memory address for a record joins two parts. The upper 9 bits come from a base register. The lower 15 bits come from the record's address word, and the top bit of that word is dropped. An address word of all ones ends the burst.

The controller keeps one internal pointer to the EEPROM byte after the last one it accessed. A burst starts at this pointer, so a burst issued before any access since reset starts at byte 0. The request bits clear themselves when their work finishes. While the block is busy, host writes are ignored.

Top module: `eeprom_loader`

## Requirements
- R1: After reset, reading any register (select 0 control, 1 address, 2 data, 3 base, 4 burst) returns 0, and ee_req and mem_we are low.
- R2: Writing control with bit 1 set performs one EEPROM read at the address register with ee_we low. Control bit 1 reads 1 until the acknowledge, then 0. The returned byte then reads back from the data register.
- R3: Writing control with bit 0 set (bit 1 clear) performs one EEPROM write of data register bits [7:0] to the address register with ee_we high. Control bit 0 then self-clears.
- R4: If control is written with bits 0 and 1 both set, only the read is performed and the EEPROM is not written.
- R5: Control bit 2 reads 1 while a single access or burst is in progress. In that time, host writes to any register, including new requests, are ignored.
- R6: Writing the burst register with bit 0 set starts a burst at EEPROM address 0 if no byte has been accessed since reset. Otherwise the burst starts at the address after the last byte accessed, whether by a single access or by a burst.
- R7: Each burst record is 2 address bytes then 4 data bytes, both least significant byte first. Each record produces exactly one single-cycle mem_we, carrying the assembled 32-bit data word.
- R8: mem_addr equals {base register[8:0], record address word[14:0]}; bit 15 of the word is ignored.
- R9: A record address word of 0xFFFF ends the burst without a memory write. The burst register bit 0 and the busy bit then return to 0.
- R10: Once ee_req is raised, it stays high and ee_addr stays stable until ee_ack. ee_req only falls after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | Request is a write |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | Byte transfer done |
| ee_rdata | input | 8 | Byte read, valid with ee_ack |
| mem_we | output | 1 | On-chip memory write pulse |
| mem_addr | output | 24 | On-chip memory address |
| mem_wdata | output | 32 | On-chip memory write data |

## Verification
The bench uses the default parameters: 16-bit EEPROM addresses, a 9-bit base, a 24-bit memory address, and records of two address bytes plus four data bytes. With these values, the dropped address bit 15, an address word whose low 15 bits are all ones, and the all-ones end marker can all be exercised with small EEPROM images. The EEPROM model answers after one to three cycles, chosen by address, so each handshake is checked at several latencies. Bursts run from reset, after single accesses, and straight into an end marker, which exercises the continuation pointer.

// File: rtl/eel_pkg.sv
package eel_pkg;
   localparam int SEL_W = 3;
   localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
   localparam logic [SEL_W-1:0] SEL_ADDR  = 3'd1;
   localparam logic [SEL_W-1:0] SEL_DATA  = 3'd2;
   localparam logic [SEL_W-1:0] SEL_BASE  = 3'd3;
   localparam logic [SEL_W-1:0] SEL_BURST = 3'd4;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SINGLE = 2'd1,
      ST_BURST  = 2'd2
   } eel_state_t;
endpackage

// File: rtl/eel_hostregs.sv
module eel_hostregs
   import eel_pkg::*;
#(
   parameter int EE_AW  = 16,
   parameter int BASE_W = 9,
   parameter int HDW    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [SEL_W-1:0]  host_sel,
   input  logic [HDW-1:0]    host_wdata,
   input  logic              busy,
   input  logic              rd_pend,
   input  logic              wr_pend,
   input  logic              burst_pend,
   input  logic              data_ld,
   input  logic [7:0]        ee_rdata,
   output logic [EE_AW-1:0]  addr_q,
   output logic [7:0]        data_q,
   output logic [BASE_W-1:0] base_q,
   output logic [HDW-1:0]    host_rdata
);
   logic wr_ok;
   assign wr_ok = host_we && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         base_q <= '0;
      end else begin
         if (wr_ok && host_sel == SEL_ADDR) addr_q <= host_wdata[EE_AW-1:0];
         if (wr_ok && host_sel == SEL_BASE) base_q <= host_wdata[BASE_W-1:0];
         if (data_ld)
            data_q <= ee_rdata;
         else if (wr_ok && host_sel == SEL_DATA)
            data_q <= host_wdata[7:0];
      end
   end

   always_comb begin
      host_rdata = '0;
      case (host_sel)
         SEL_CTRL:  host_rdata = HDW'({busy, rd_pend, wr_pend});
         SEL_ADDR:  host_rdata = HDW'(addr_q);
         SEL_DATA:  host_rdata = HDW'(data_q);
         SEL_BASE:  host_rdata = HDW'(base_q);
         SEL_BURST: host_rdata = HDW'(burst_pend);
         default:   host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/eel_seq.sv
module eel_seq
   import eel_pkg::*;
#(
   parameter int EE_AW      = 16,
   parameter int REC_ABYTES = 2,
   parameter int DATA_BYTES = 4,
   parameter int IDX_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [SEL_W-1:0]  host_sel,
   input  logic [1:0]        host_bits,
   input  logic [EE_AW-1:0]  addr_q,
   input  logic [7:0]        data_q,
   input  logic              ee_ack,
   input  logic              end_mark,
   output logic              ee_req,
   output logic              ee_we,
   output logic [EE_AW-1:0]  ee_addr,
   output logic [7:0]        ee_wdata,
   output logic              busy,
   output logic              rd_pend,
   output logic              wr_pend,
   output logic              burst_pend,
   output logic              data_ld,
   output logic              byte_vld,
   output logic [IDX_W-1:0]  byte_idx
);
   localparam int REC_BYTES = REC_ABYTES + DATA_BYTES;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(REC_BYTES - 1);

   eel_state_t       state;
   logic             op_wr;
   logic [EE_AW-1:0] ptr;
   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         op_wr <= 1'b0;
         ptr   <= '0;
         idx   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (host_we && host_sel == SEL_CTRL) begin
                  if (host_bits[1]) begin
                     state <= ST_SINGLE;
                     op_wr <= 1'b0;
                  end else if (host_bits[0]) begin
                     state <= ST_SINGLE;
                     op_wr <= 1'b1;
                  end
               end else if (host_we && host_sel == SEL_BURST && host_bits[0]) begin
                  state <= ST_BURST;
                  idx   <= '0;
               end
            end
            ST_SINGLE: begin
               if (ee_ack) begin
                  ptr   <= addr_q + 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_BURST: begin
               if (ee_ack) begin
                  ptr <= ptr + 1'b1;
                  if (end_mark) begin
                     state <= ST_IDLE;
                     idx   <= '0;
                  end else if (idx == IDX_LAST) begin
                     idx <= '0;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state != ST_IDLE);
   assign ee_req     = busy;
   assign ee_we      = (state == ST_SINGLE) && op_wr;
   assign ee_addr    = (state == ST_SINGLE) ? addr_q : ptr;
   assign ee_wdata   = data_q;
   assign rd_pend    = (state == ST_SINGLE) && !op_wr;
   assign wr_pend    = (state == ST_SINGLE) && op_wr;
   assign burst_pend = (state == ST_BURST);
   assign data_ld    = rd_pend && ee_ack;
   assign byte_vld   = burst_pend && ee_ack;
   assign byte_idx   = idx;
endmodule

// File: rtl/eel_asm.sv
module eel_asm #(
   parameter int REC_ABYTES = 2,
   parameter int DATA_BYTES = 4,
   parameter int BASE_W     = 9,
   parameter int MEM_AW     = 24,
   parameter int IDX_W      = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_vld,
   input  logic [IDX_W-1:0]        byte_idx,
   input  logic [7:0]              byte_in,
   input  logic [BASE_W-1:0]       base_q,
   output logic                    end_mark,
   output logic                    mem_we,
   output logic [MEM_AW-1:0]       mem_addr,
   output logic [8*DATA_BYTES-1:0] mem_wdata
);
   localparam int REC_BYTES = REC_ABYTES + DATA_BYTES;
   localparam int AWW       = 8 * REC_ABYTES;
   localparam int LOW_W     = MEM_AW - BASE_W;
   localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(REC_BYTES - 1);
   localparam logic [IDX_W-1:0] IDX_AHIGH = IDX_W'(REC_ABYTES - 1);

   logic [7:0]              lane_q [REC_BYTES];
   logic [7:0]              cur    [REC_BYTES];
   logic [AWW-1:0]          addr_word;
   logic [8*DATA_BYTES-1:0] data_word;

   for (genvar i = 0; i < REC_BYTES; i++) begin : g_lane
      logic hit;
      assign hit    = byte_vld && (byte_idx == IDX_W'(i));
      assign cur[i] = hit ? byte_in : lane_q[i];
      always_ff @(posedge clk) begin
         if (!rst_n)   lane_q[i] <= '0;
         else if (hit) lane_q[i] <= byte_in;
      end
   end

   for (genvar j = 0; j < REC_ABYTES; j++) begin : g_aw
      assign addr_word[8*j +: 8] = cur[j];
   end

   for (genvar k = 0; k < DATA_BYTES; k++) begin : g_dw
      assign data_word[8*k +: 8] = cur[REC_ABYTES + k];
   end

   assign end_mark = byte_vld && (byte_idx == IDX_AHIGH) && (&addr_word);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= byte_vld && (byte_idx == IDX_LAST);
         if (byte_vld && (byte_idx == IDX_LAST)) begin
            mem_addr  <= {base_q, addr_word[LOW_W-1:0]};
            mem_wdata <= data_word;
         end
      end
   end
endmodule

// File: rtl/eeprom_loader.sv
module eeprom_loader
   import eel_pkg::*;
#(
   parameter int EE_AW      = 16,
   parameter int BASE_W     = 9,
   parameter int MEM_AW     = 24,
   parameter int REC_ABYTES = 2,
   parameter int DATA_BYTES = 4,
   parameter int HDW        = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    host_we,
   input  logic [SEL_W-1:0]        host_sel,
   input  logic [HDW-1:0]          host_wdata,
   output logic [HDW-1:0]          host_rdata,
   output logic                    ee_req,
   output logic                    ee_we,
   output logic [EE_AW-1:0]        ee_addr,
   output logic [7:0]              ee_wdata,
   input  logic                    ee_ack,
   input  logic [7:0]              ee_rdata,
   output logic                    mem_we,
   output logic [MEM_AW-1:0]       mem_addr,
   output logic [8*DATA_BYTES-1:0] mem_wdata
);
   localparam int REC_BYTES = REC_ABYTES + DATA_BYTES;
   localparam int IDX_W     = (REC_BYTES > 1) ? $clog2(REC_BYTES) : 1;
   localparam int LOW_W     = MEM_AW - BASE_W;

   if (LOW_W < 1 || LOW_W > 8 * REC_ABYTES - 1) begin : g_bad_split
      $error("memory low part must fit below the top bit of the record address word");
   end
   if (HDW < EE_AW || HDW < BASE_W || HDW < 8) begin : g_bad_hdw
      $error("host data width too narrow for the registers");
   end
   if (DATA_BYTES < 1 || REC_ABYTES < 1) begin : g_bad_rec
      $error("record needs at least one address and one data byte");
   end

   logic              busy, rd_pend, wr_pend, burst_pend;
   logic              data_ld, byte_vld, end_mark;
   logic [IDX_W-1:0]  byte_idx;
   logic [EE_AW-1:0]  addr_q;
   logic [7:0]        data_q;
   logic [BASE_W-1:0] base_q;

   eel_hostregs #(.EE_AW(EE_AW), .BASE_W(BASE_W), .HDW(HDW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_sel   (host_sel),
      .host_wdata (host_wdata),
      .busy       (busy),
      .rd_pend    (rd_pend),
      .wr_pend    (wr_pend),
      .burst_pend (burst_pend),
      .data_ld    (data_ld),
      .ee_rdata   (ee_rdata),
      .addr_q     (addr_q),
      .data_q     (data_q),
      .base_q     (base_q),
      .host_rdata (host_rdata)
   );

   eel_seq #(.EE_AW(EE_AW), .REC_ABYTES(REC_ABYTES), .DATA_BYTES(DATA_BYTES),
             .IDX_W(IDX_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_sel   (host_sel),
      .host_bits  (host_wdata[1:0]),
      .addr_q     (addr_q),
      .data_q     (data_q),
      .ee_ack     (ee_ack),
      .end_mark   (end_mark),
      .ee_req     (ee_req),
      .ee_we      (ee_we),
      .ee_addr    (ee_addr),
      .ee_wdata   (ee_wdata),
      .busy       (busy),
      .rd_pend    (rd_pend),
      .wr_pend    (wr_pend),
      .burst_pend (burst_pend),
      .data_ld    (data_ld),
      .byte_vld   (byte_vld),
      .byte_idx   (byte_idx)
   );

   eel_asm #(.REC_ABYTES(REC_ABYTES), .DATA_BYTES(DATA_BYTES), .BASE_W(BASE_W),
             .MEM_AW(MEM_AW), .IDX_W(IDX_W)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_vld  (byte_vld),
      .byte_idx  (byte_idx),
      .byte_in   (ee_rdata),
      .base_q    (base_q),
      .end_mark  (end_mark),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );
endmodule

// File: rtl/eel_checker.sv
module eel_checker
   import eel_pkg::*;
#(
   parameter int EE_AW  = 16,
   parameter int BASE_W = 9,
   parameter int MEM_AW = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic [SEL_W-1:0]  host_sel,
   input logic              ee_req,
   input logic              ee_ack,
   input logic [EE_AW-1:0]  ee_addr,
   input logic              mem_we,
   input logic [MEM_AW-1:0] mem_addr,
   input logic [BASE_W-1:0] base_q,
   input logic [EE_AW-1:0]  addr_q,
   input logic              busy
);
   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr)));

   // R10
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_req) |-> $past(ee_ack));

   // R7
   mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R8
   mem_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[MEM_AW-1 -: BASE_W] == base_q));

   // R5
   busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_we && host_sel == SEL_ADDR) |=> $stable(addr_q));

   // R5
   busy_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_we && host_sel == SEL_BASE) |=> $stable(base_q));
endmodule

bind eeprom_loader eel_checker #(.EE_AW(EE_AW), .BASE_W(BASE_W), .MEM_AW(MEM_AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .host_we  (host_we),
   .host_sel (host_sel),
   .ee_req   (ee_req),
   .ee_ack   (ee_ack),
   .ee_addr  (ee_addr),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .base_q   (base_q),
   .addr_q   (addr_q),
   .busy     (busy)
);

// File: tb/sim_eeprom_loader.sv
module sim_eeprom_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [2:0]  host_sel = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        ee_req, ee_we;
   logic [15:0] ee_addr;
   logic [7:0]  ee_wdata;
   logic        ee_ack = 1'b0;
   logic [7:0]  ee_rdata = '0;
   logic        mem_we;
   logic [23:0] mem_addr;
   logic [31:0] mem_wdata;

   int nchk = 0;
   int nfail = 0;
   int hs_viol = 0;
   logic [55:0] exp_q [$];
   logic [7:0]  eemem [logic [15:0]];

   always #5 clk = ~clk;

   eeprom_loader u0 (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
      .ee_ack(ee_ack), .ee_rdata(ee_rdata),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   function automatic logic [7:0] dflt(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic logic [7:0] ee_rd(input logic [15:0] a);
      return eemem.exists(a) ? eemem[a] : dflt(a);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // EEPROM model: acknowledges after 1..3 cycles depending on address
   int cnt = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         ee_ack <= 1'b0;
         cnt    <= 0;
      end else begin
         ee_ack <= 1'b0;
         if (ee_req && !ee_ack) begin
            if (cnt >= 1 + int'(ee_addr % 3)) begin
               ee_ack <= 1'b1;
               cnt    <= 0;
               if (ee_we) eemem[ee_addr] = ee_wdata;
               else       ee_rdata <= ee_rd(ee_addr);
            end else begin
               cnt <= cnt + 1;
            end
         end
      end
   end

   // handshake observer (R10)
   logic        p_req = 1'b0, p_ack = 1'b0;
   logic [15:0] p_addr = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (p_req && !p_ack && (!ee_req || ee_addr !== p_addr)) hs_viol++;
         p_req  <= ee_req;
         p_ack  <= ee_ack;
         p_addr <= ee_addr;
      end
   end

   // scoreboard monitor (R7, R8)
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         if (exp_q.size() == 0) begin
            check("R9 no write expected", 32'd1, 32'd0);
         end else begin
            logic [55:0] e;
            e = exp_q.pop_front();
            check("R8 mem_addr", {8'h0, mem_addr}, {8'h0, e[55:32]});
            check("R7 mem_wdata", mem_wdata, e[31:0]);
         end
      end
   end

   task automatic hwr(input logic [2:0] s, input logic [31:0] v);
      @(negedge clk);
      host_we = 1'b1; host_sel = s; host_wdata = v;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic hrd(input logic [2:0] s, output logic [31:0] v);
      @(negedge clk);
      host_sel = s;
      #1 v = host_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 2000; i++) begin
         hrd(3'd0, v);
         if (!v[2]) break;
      end
   endtask

   task automatic put_rec(inout logic [15:0] p, input logic [15:0] aw, input logic [31:0] dw,
                          input logic [8:0] base, input logic expect_it);
      eemem[p] = aw[7:0];  p++;
      eemem[p] = aw[15:8]; p++;
      for (int b = 0; b < 4; b++) begin
         eemem[p] = dw[8*b +: 8]; p++;
      end
      if (expect_it) exp_q.push_back({base, aw[14:0], dw});
   endtask

   task automatic put_end(inout logic [15:0] p);
      eemem[p] = 8'hFF; p++;
      eemem[p] = 8'hFF; p++;
   endtask

   initial begin
      #(200000 * 10);
      nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [15:0] p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int s = 0; s < 5; s++) begin
         hrd(3'(s), v);
         check("R1 register reset", v, 32'h0);
      end
      check("R1 ee_req", {31'h0, ee_req}, 32'h0);
      check("R1 mem_we", {31'h0, mem_we}, 32'h0);

      // R6 first burst from address 0, R7/R8 records, R9 end
      p = 16'h0000;
      put_rec(p, 16'h8123, 32'hDEADBEEF, 9'h1A5, 1'b1);
      put_rec(p, 16'h0042, 32'h01020304, 9'h1A5, 1'b1);
      put_end(p);
      hwr(3'd3, 32'h1A5);
      hwr(3'd4, 32'h1);
      hrd(3'd4, v);
      check("R6 burst bit pending", v, 32'h1);
      hwr(3'd1, 32'h55);   // ignored while busy (R5)
      hwr(3'd3, 32'h0EE);  // ignored while busy (R5)
      hwr(3'd0, 32'h2);    // ignored while busy (R5)
      hrd(3'd0, v);
      check("R5 busy bit", v, 32'h4);
      wait_idle();
      hrd(3'd1, v);
      check("R5 address write ignored", v, 32'h0);
      hrd(3'd3, v);
      check("R5 base write ignored", v, 32'h1A5);
      hrd(3'd4, v);
      check("R9 burst bit cleared", v, 32'h0);
      check("R7 all records written", exp_q.size(), 32'd0);

      // R3 single write
      hwr(3'd1, 32'h0100);
      hwr(3'd2, 32'hA7);
      hwr(3'd0, 32'h1);
      hrd(3'd0, v);
      check("R3 write pending", v, 32'h5);
      wait_idle();
      hrd(3'd0, v);
      check("R3 write bit cleared", v, 32'h0);
      check("R3 eeprom byte", {24'h0, ee_rd(16'h0100)}, 32'hA7);

      // R2 single read
      hwr(3'd2, 32'h00);
      hwr(3'd0, 32'h2);
      hrd(3'd0, v);
      check("R2 read pending", v, 32'h6);
      wait_idle();
      hrd(3'd0, v);
      check("R2 read bit cleared", v, 32'h0);
      hrd(3'd2, v);
      check("R2 data read back", v, 32'hA7);

      // R4 both bits: read only
      hwr(3'd1, 32'h0200);
      hwr(3'd2, 32'h33);
      hwr(3'd0, 32'h3);
      wait_idle();
      hrd(3'd2, v);
      check("R4 read performed", v, {24'h0, dflt(16'h0200)});
      check("R4 no write", {31'h0, eemem.exists(16'h0200)}, 32'h0);

      // R6 continuation after single access at 0x0200
      p = 16'h0201;
      put_rec(p, 16'h7FFF, 32'hCAFEF00D, 9'h003, 1'b1);
      put_end(p);
      hwr(3'd3, 32'h003);
      hwr(3'd4, 32'h1);
      wait_idle();
      check("R6 continuation record", exp_q.size(), 32'd0);

      // R6 continuation after burst, R9 immediate end marker
      put_end(p);
      hwr(3'd4, 32'h1);
      wait_idle();
      hrd(3'd0, v);
      check("R9 idle after immediate end", v, 32'h0);
      hrd(3'd4, v);
      check("R9 burst bit cleared", v, 32'h0);
      repeat (3) @(negedge clk);
      check("R10 handshake violations", hs_viol, 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule